// File: doc/BRIEF.md
# Eight-Channel Interval Timer with Stop-After-Expiry

The block is a bank of eight down-counting interval timers that share one count-enable tick. Each channel is reloaded from its own programmable load value and raises a one-cycle time-out pulse each time its count expires. A channel can be told to stop after its next time-out instead of reloading. It then waits in a halted state until software writes its force-load bit. A channel in external-trigger mode can also be restarted by a pulse on its trigger input.

The stop setting is double-buffered. Software writes a visible stop bit, and the channel copies it into a private working bit only when it restarts: on enable, on force-load, on an external restart, or on an automatic reload after a time-out. The load value is taken at the same moments. A write to either therefore governs the run that follows the next restart, not the one in progress. A second mask selects which channels' time-outs are merged into a single combined trigger pulse, which can drive other logic on a programmed timing sequence. Software reaches every setting through a byte-wide register bus with single-cycle writes and combinational reads.

Top module: `ivt_timer`

## Requirements
- R1: After reset, every register reads 0x00 and `tout_o` and `comb_trig_o` are low.
- R2: A running channel loses one count on each clock edge where `tick_i` is high. On a tick that finds the count at zero, the channel signals a time-out and reloads, so the period is (load + 1) ticks.
- R3: While a channel's enable bit is 0, its count is frozen and it produces no time-out. A 0-to-1 change of the enable bit restarts the channel from its load value on the clock edge after the write.
- R4: The stop bit written by software is copied into the channel's working copy only at a restart or reload. A write to it during a run takes effect only after the next restart.
- R5: A channel whose working stop copy is 1 halts after its next time-out. It produces no further time-outs until it is restarted.
- R6: Writing 1 to bit c of the force register (offset 0x13) restarts channel c from its load value at that same clock edge, whether it is running or halted. The stop bit is copied at the same edge. The force register always reads 0x00.
- R7: When the external-mode bit of channel c is 1 and the channel is halted, `ext_trig_i[c]` high at a clock edge restarts it. The input is ignored by a running channel and by a channel not in external mode.
- R8: A time-out sets the channel's sticky flag (offset 0x14). Writing 1 to a flag bit clears it, but a time-out in the same cycle leaves the flag set.
- R9: `comb_trig_o` is high for exactly the cycles in which some channel whose trigger-enable bit (offset 0x12) is 1 shows a time-out on `tout_o`.
- R10: `tout_o[c]` is high for the single cycle that follows the clock edge on which channel c timed out.
- R11: The register map is as follows. The load value of channel c is little-endian at offsets 2c (low byte) and 2c+1 (high byte). Enable is at 0x10, stop at 0x11, trigger-enable at 0x12, force at 0x13, flags at 0x14 and external mode at 0x15, with bit c for channel c. Other offsets read 0x00 and ignore writes.
- R12: When a restart and an expiring tick coincide, the restart wins and no time-out is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Shared count-enable tick |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` (combinational) |
| ext_trig_i | input | 8 | Per-channel external restart inputs |
| tout_o | output | 8 | Per-channel one-cycle time-out pulses |
| comb_trig_o | output | 1 | Combined trigger pulse of the selected channels |

## Verification
A wrong working stop copy shows up only one period later. The channel either keeps pulsing when it should have halted, or goes quiet one run early, so the scoreboard has to follow every channel across several reloads. A wrong count or load capture moves the next `tout_o` pulse by a whole number of ticks, which the tick-by-tick comparison catches at the first time-out after the fault. A lost or stuck halted state shows as a missing or extra pulse after a force-load or an external trigger. Flag and combined-trigger faults appear in the same cycle as the pulse that caused them.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int DEF_NCH = 8;
  localparam int DEF_CW  = 16;
  localparam int DEF_AW  = 6;

  // Control register order after the load-value window
  typedef enum int {
    OFS_EN    = 0,
    OFS_STOP  = 1,
    OFS_TRIG  = 2,
    OFS_FORCE = 3,
    OFS_FLAG  = 4,
    OFS_XMODE = 5
  } ctrl_ofs_e;

  // Byte offset of byte b of channel ch's load value
  function automatic int load_addr(int ch, int b, int lb);
    return ch * lb + b;
  endfunction

  // Offset of a control register, placed right after the load window
  function automatic int ctrl_addr(int nch, int lb, ctrl_ofs_e ofs);
    return nch * lb + int'(ofs);
  endfunction
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs import ivt_pkg::*; #(
  parameter int NCH = DEF_NCH,
  parameter int CW  = DEF_CW,
  parameter int AW  = DEF_AW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [7:0]               wdata_i,
  output logic [7:0]               rdata_o,
  input  logic [NCH-1:0]           to_i,
  output logic [NCH-1:0][CW-1:0]   load_o,
  output logic [NCH-1:0]           en_o,
  output logic [NCH-1:0]           stop_o,
  output logic [NCH-1:0]           trig_o,
  output logic [NCH-1:0]           xmode_o,
  output logic [NCH-1:0]           force_o,
  output logic [NCH-1:0]           flag_o
);
  localparam int LB      = CW / 8;
  localparam int A_EN    = NCH * LB + int'(OFS_EN);
  localparam int A_STOP  = NCH * LB + int'(OFS_STOP);
  localparam int A_TRIG  = NCH * LB + int'(OFS_TRIG);
  localparam int A_FORCE = NCH * LB + int'(OFS_FORCE);
  localparam int A_FLAG  = NCH * LB + int'(OFS_FLAG);
  localparam int A_XMODE = NCH * LB + int'(OFS_XMODE);

  logic [NCH-1:0][CW-1:0] load_q;
  logic [NCH-1:0]         en_q, stop_q, trig_q, xmode_q, flag_q;
  logic                   wr_en, wr_stop, wr_trig, wr_force, wr_flag, wr_xmode;
  logic [NCH-1:0]         flag_clr;

  assign wr_en    = we_i && (addr_i == AW'(A_EN));
  assign wr_stop  = we_i && (addr_i == AW'(A_STOP));
  assign wr_trig  = we_i && (addr_i == AW'(A_TRIG));
  assign wr_force = we_i && (addr_i == AW'(A_FORCE));
  assign wr_flag  = we_i && (addr_i == AW'(A_FLAG));
  assign wr_xmode = we_i && (addr_i == AW'(A_XMODE));

  assign flag_clr = wr_flag ? wdata_i[NCH-1:0] : '0;
  assign force_o  = wr_force ? wdata_i[NCH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q  <= '0;
      en_q    <= '0;
      stop_q  <= '0;
      trig_q  <= '0;
      xmode_q <= '0;
      flag_q  <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        for (int b = 0; b < LB; b++) begin
          if (we_i && (addr_i == AW'(load_addr(c, b, LB))))
            load_q[c][b*8 +: 8] <= wdata_i;
        end
      end
      if (wr_en)    en_q    <= wdata_i[NCH-1:0];
      if (wr_stop)  stop_q  <= wdata_i[NCH-1:0];
      if (wr_trig)  trig_q  <= wdata_i[NCH-1:0];
      if (wr_xmode) xmode_q <= wdata_i[NCH-1:0];
      // a time-out in the same cycle beats a clear (R8)
      flag_q <= to_i | (flag_q & ~flag_clr);
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int c = 0; c < NCH; c++) begin
      for (int b = 0; b < LB; b++) begin
        if (addr_i == AW'(load_addr(c, b, LB)))
          rdata_o = load_q[c][b*8 +: 8];
      end
    end
    if (addr_i == AW'(A_EN))    rdata_o = 8'(en_q);
    if (addr_i == AW'(A_STOP))  rdata_o = 8'(stop_q);
    if (addr_i == AW'(A_TRIG))  rdata_o = 8'(trig_q);
    if (addr_i == AW'(A_FLAG))  rdata_o = 8'(flag_q);
    if (addr_i == AW'(A_XMODE)) rdata_o = 8'(xmode_q);
  end

  assign load_o  = load_q;
  assign en_o    = en_q;
  assign stop_o  = stop_q;
  assign trig_o  = trig_q;
  assign xmode_o = xmode_q;
  assign flag_o  = flag_q;

  for (genvar c = 0; c < NCH; c++) begin : g_flag_chk
    // R8: a time-out always leaves its flag set
    assert_flag_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      to_i[c] |=> flag_q[c]);
  end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel import ivt_pkg::*; #(
  parameter int CW = DEF_CW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          stop_i,
  input  logic          force_i,
  input  logic          xmode_i,
  input  logic          ext_i,
  input  logic [CW-1:0] load_i,
  output logic          to_o
);
  function automatic logic expired(logic [CW-1:0] v);
    return v == '0;
  endfunction

  function automatic logic [CW-1:0] dec(logic [CW-1:0] v);
    return v - CW'(1);
  endfunction

  logic [CW-1:0] cnt_q;
  logic          stop_w_q, halted_q, en_q;
  logic          en_rise, ext_go, restart, count_ok, to_ev;

  assign en_rise  = en_i & ~en_q;
  assign ext_go   = xmode_i & ext_i & halted_q;
  assign restart  = en_i & (en_rise | force_i | ext_go);
  assign count_ok = en_i & ~halted_q & tick_i & ~restart;
  assign to_ev    = count_ok & expired(cnt_q);
  assign to_o     = to_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stop_w_q <= 1'b0;
      halted_q <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      en_q <= en_i;
      if (restart) begin
        cnt_q    <= load_i;
        stop_w_q <= stop_i;
        halted_q <= 1'b0;
      end else if (count_ok) begin
        if (expired(cnt_q)) begin
          if (stop_w_q) begin
            halted_q <= 1'b1;
          end else begin
            cnt_q    <= load_i;
            stop_w_q <= stop_i;
          end
        end else begin
          cnt_q <= dec(cnt_q);
        end
      end
    end
  end

  // R3: a disabled channel holds its count
  assert_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  // R6: any restart takes the load value present at that edge
  assert_restart_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (cnt_q == $past(load_i)));
  // R5: halting only follows a time-out under a set working stop copy
  assert_halt_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_q) |-> $past(to_ev && stop_w_q));
  // R5: a halted channel stays halted until restarted
  assert_halt_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_q && !restart) |=> halted_q);
  // R4: the working stop copy moves only at restart or reload
  assert_stopw_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stop_w_q) |-> $past(restart || to_ev));
endmodule

// File: rtl/ivt_merge.sv
module ivt_merge #(
  parameter int NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] to_i,
  input  logic [NCH-1:0] trig_i,
  output logic [NCH-1:0] tout_o,
  output logic           comb_o
);
  logic [NCH-1:0] tout_q;
  logic           comb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tout_q <= '0;
      comb_q <= 1'b0;
    end else begin
      tout_q <= to_i;
      comb_q <= |(to_i & trig_i);
    end
  end

  assign tout_o = tout_q;
  assign comb_o = comb_q;

  // R9: the combined pulse never appears without a channel pulse
  assert_comb_subset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comb_q |-> (|tout_q));
  // R9: a selected time-out always reaches the combined output
  assert_comb_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(to_i & trig_i)) |=> comb_q);
  // R10: each pulse mirrors a time-out of the previous cycle
  assert_tout_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tout_q) |-> $past(|to_i));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer import ivt_pkg::*; #(
  parameter int NCH = DEF_NCH,
  parameter int CW  = DEF_CW,
  parameter int AW  = DEF_AW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           bus_we_i,
  input  logic [AW-1:0]  bus_addr_i,
  input  logic [7:0]     bus_wdata_i,
  output logic [7:0]     bus_rdata_o,
  input  logic [NCH-1:0] ext_trig_i,
  output logic [NCH-1:0] tout_o,
  output logic           comb_trig_o
);
  logic [NCH-1:0][CW-1:0] load_w;
  logic [NCH-1:0]         en_w, stop_w, trig_w, xmode_w, force_w, flag_w, to_w;

  ivt_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .to_i    (to_w),
    .load_o  (load_w),
    .en_o    (en_w),
    .stop_o  (stop_w),
    .trig_o  (trig_w),
    .xmode_o (xmode_w),
    .force_o (force_w),
    .flag_o  (flag_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ivt_channel #(.CW(CW)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .en_i    (en_w[c]),
      .stop_i  (stop_w[c]),
      .force_i (force_w[c]),
      .xmode_i (xmode_w[c]),
      .ext_i   (ext_trig_i[c]),
      .load_i  (load_w[c]),
      .to_o    (to_w[c])
    );
  end

  ivt_merge #(.NCH(NCH)) u_merge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .to_i   (to_w),
    .trig_i (trig_w),
    .tout_o (tout_o),
    .comb_o (comb_trig_o)
  );

  // R8: a visible pulse always finds its flag set
  assert_pulse_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tout_o & ~flag_w) == '0);
endmodule

// File: tb/ivt_timer_tb_top.sv
module ivt_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0, ext = '0;
  logic [7:0] rdata, tout;
  logic       comb;

  always #10 clk = ~clk;

  ivt_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .ext_trig_i(ext), .tout_o(tout), .comb_trig_o(comb)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  string cur_tag = "R1";

  typedef struct { logic [7:0] tout; logic comb; string tag; } exp_t;
  exp_t sb[$];

  // reference model state
  int         m_cnt[8];
  bit         m_halt[8], m_stopw[8], m_enq[8];
  logic [15:0] m_load[8];
  logic [7:0] m_en = 0, m_stop = 0, m_trig = 0, m_xm = 0, m_flag = 0;

  function automatic logic [7:0] model_read(logic [5:0] a);
    if (a < 6'h10) return m_load[a >> 1][(a & 1) * 8 +: 8];
    case (a)
      6'h10: return m_en;
      6'h11: return m_stop;
      6'h12: return m_trig;
      6'h14: return m_flag;
      6'h15: return m_xm;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_edge(bit tk, bit w, logic [5:0] a, logic [7:0] d, logic [7:0] x);
    logic [7:0] fl, clr, tov;
    exp_t e;
    fl  = (w && a == 6'h13) ? d : 8'h00;
    clr = (w && a == 6'h14) ? d : 8'h00;
    tov = 8'h00;
    for (int c = 0; c < 8; c++) begin
      bit en, go;
      en = m_en[c];
      go = en && (!m_enq[c] || fl[c] || (m_xm[c] && x[c] && m_halt[c]));
      if (go) begin
        m_cnt[c] = m_load[c]; m_stopw[c] = m_stop[c]; m_halt[c] = 0;
      end else if (en && !m_halt[c] && tk) begin
        if (m_cnt[c] == 0) begin
          tov[c] = 1'b1;
          if (m_stopw[c]) m_halt[c] = 1;
          else begin m_cnt[c] = m_load[c]; m_stopw[c] = m_stop[c]; end
        end else m_cnt[c] = m_cnt[c] - 1;
      end
      m_enq[c] = en;
    end
    e.tout = tov; e.comb = |(tov & m_trig); e.tag = cur_tag;
    sb.push_back(e);
    m_flag = tov | (m_flag & ~clr);
    if (w) begin
      if (a < 6'h10) m_load[a >> 1][(a & 1) * 8 +: 8] = d;
      else case (a)
        6'h10: m_en = d;
        6'h11: m_stop = d;
        6'h12: m_trig = d;
        6'h15: m_xm = d;
        default: ;
      endcase
    end
  endtask

  // driver: one clock of stimulus, expected result goes to the scoreboard
  task automatic step(bit tk, bit w, logic [5:0] a, logic [7:0] d, logic [7:0] x);
    @(negedge clk);
    tick = tk; we = w; addr = a; wdata = d; ext = x;
    model_edge(tk, w, a, d, x);
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    step(0, 1, a, d, 0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1, 0, 6'h3F, 0, 0);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd_check(logic [5:0] a, string tag);
    logic [7:0] e;
    e = model_read(a);
    step(0, 0, a, 0, 0);
    #1 chk(tag, rdata, e);
  endtask

  // monitor: compares the pulse outputs after every driven edge
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (tout !== e.tout || comb !== e.comb) begin
        n_fail++;
        $display("FAIL %s: tout=%02h comb=%0b expected tout=%02h comb=%0b",
                 e.tag, tout, comb, e.tout, e.comb);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    for (int c = 0; c < 8; c++) begin
      m_cnt[c] = 0; m_halt[c] = 0; m_stopw[c] = 0; m_enq[c] = 0; m_load[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    #1 chk("R1 tout", tout, 8'h00);
    chk("R1 comb", {7'd0, comb}, 8'h00);
    rd_check(6'h10, "R1 enable");
    rd_check(6'h11, "R1 stop");
    rd_check(6'h12, "R1 trig");
    rd_check(6'h14, "R1 flags");
    rd_check(6'h00, "R1 load");

    // R11: register map
    cur_tag = "R11";
    wr(6'h00, 8'h03); wr(6'h01, 8'h00);
    wr(6'h02, 8'h05); wr(6'h03, 8'h00);
    wr(6'h04, 8'h02); wr(6'h05, 8'h01);
    wr(6'h06, 8'h00); wr(6'h07, 8'h00);
    wr(6'h20, 8'hFF);
    rd_check(6'h04, "R11 load2 lo");
    rd_check(6'h05, "R11 load2 hi");
    chk("R11 load2 literal", model_read(6'h05), 8'h01);
    rd_check(6'h20, "R11 unmapped");

    // R2/R9/R10: periodic run, ch0 in the combined trigger
    cur_tag = "R9";
    wr(6'h12, 8'h01);
    cur_tag = "R2";
    wr(6'h10, 8'h03);
    cur_tag = "R10";
    ticks(14);
    rd_check(6'h14, "R8 flags after run");

    // R4/R5: stop written mid-run acts after the next restart
    cur_tag = "R4";
    wr(6'h11, 8'h01);
    ticks(6);
    cur_tag = "R5";
    ticks(10);

    // R8: write-one-to-clear, also together with ticks
    cur_tag = "R8";
    wr(6'h14, 8'h01);
    rd_check(6'h14, "R8 clear ch0");
    step(1, 1, 6'h14, 8'hFF, 0);
    step(1, 1, 6'h14, 8'hFF, 0);
    ticks(4);
    rd_check(6'h14, "R8 flags");

    // R6: force-load restarts a halted channel; force reads zero
    cur_tag = "R6";
    wr(6'h13, 8'h01);
    rd_check(6'h13, "R6 force reads zero");
    ticks(8);

    // R7: external restart of ch1, ignored for ch0 (not in mode)
    cur_tag = "R7";
    wr(6'h11, 8'h03);
    wr(6'h15, 8'h02);
    ticks(14);
    step(0, 0, 6'h3F, 0, 8'h03);
    ticks(2);
    step(0, 0, 6'h3F, 0, 8'h02);
    ticks(8);

    // R12: ch3 with load 0 expires every tick; force on an expiring tick
    cur_tag = "R12";
    wr(6'h11, 8'h00);
    wr(6'h10, 8'h0B);
    ticks(3);
    step(1, 1, 6'h13, 8'h08, 0);
    ticks(2);

    // R3: freeze and re-enable
    cur_tag = "R3";
    wr(6'h10, 8'h09);
    ticks(9);
    wr(6'h10, 8'h0B);
    ticks(9);

    step(0, 0, 6'h3F, 0, 0);
    repeat (3) @(posedge clk);
    #6 finish_run();
  end
endmodule